// File: doc/BRIEF.md
# Auxiliary Channel Transition Budget Monitor

This block watches one or two slow auxiliary data lines that ride beside a main serial stream. It flags any line whose activity goes past a fixed budget. Time is cut into back-to-back windows, each a set number of enabled transmit-clock cycles long. At most two transitions may fall inside one window. The window length depends on the selected operating mode. Two transitions on successive enabled samples are treated as one event, so a narrow pulse costs only one unit of the budget.

At the end of each window, the block raises a one-cycle violation flag for every lane that went over budget. A sticky error bit records that at least one violation has occurred since reset. The block only checks the lines. It does not carry the data anywhere.

Top module: `aux_toggle_budget`

## Requirements
- R1: After reset, `viol_o` and `err_o` are all zero. They stay zero while no window has closed.
- R2: Windows are contiguous and count only cycles with `en_i` high. The first window starts at the first enabled cycle after reset. `mode_i` encoding: 2'b00 is single lane with long windows, 2'b01 is dual lane with short windows, 2'b10 is single lane with short windows, and 2'b11 behaves like 2'b00. Long windows are 512 enabled cycles and short windows are 128.
- R3: Each lane compares its input with its previous enabled sample, only on enabled cycles. Changes that come and go while `en_i` is low are not seen. The first enabled sample after reset never counts as a transition.
- R4: A transition is counted unless the previous enabled sample of the same lane already produced a counted transition. So a back-to-back pair counts once, and this rule also applies across a window boundary. The lane's count saturates at 3.
- R5: When a window closes with more than 2 counted transitions on lane i, `viol_o[i]` is high for exactly the one cycle after that closing edge. A window with 2 or fewer counted transitions gives no pulse.
- R6: In dual mode, lane 1 (`din_i[1]`) is budgeted independently of lane 0 and reports on `viol_o[1]`.
- R7: In the single-lane modes, `din_i[1]` is ignored and `viol_o[1]` stays low. Lane 1's history is cleared, so its first enabled sample after entering dual mode is not a transition.
- R8: `err_o` rises on the edge after any `viol_o` pulse. It then stays high until reset.
- R9: If the mode changes to short windows while the current window has already run at least 127 enabled cycles, that window closes on the next enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Enable: one transmit-clock period per high cycle |
| mode_i | input | 2 | Operating mode (see R2) |
| din_i | input | 2 | Auxiliary data lines, bit 0 = lane 0, bit 1 = lane 1 |
| viol_o | output | 2 | Per-lane one-cycle over-budget pulse at window end |
| err_o | output | 1 | Sticky error: some violation since reset |

## Verification
The hardest situations to reach are the merge rule across a window boundary and the early close of a window after a mode change. Both need transitions placed on exact enabled-cycle indices, hundreds of cycles after reset. The bench keeps its own count of enabled edges. It places a back-to-back pair on the last cycle of one window and the first cycle of the next. It also switches from long to short windows after 300 enabled cycles. For the gating check, it places glitches on both lanes in disabled cycles between every enabled sample.

// File: rtl/aux_toggle_pkg.sv
`timescale 1ns/1ps
package aux_toggle_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_DUAL   = 2'b01,
        MODE_FAST   = 2'b10,
        MODE_RSVD   = 2'b11
    } aux_mode_e;

    localparam int unsigned LONG_WIN_DEF  = 512;
    localparam int unsigned SHORT_WIN_DEF = 128;
    localparam int unsigned BUDGET_DEF    = 2;
endpackage

// File: rtl/aux_toggle_window.sv
`timescale 1ns/1ps
module aux_toggle_window #(
    parameter int unsigned LONG_LEN  = 512,
    parameter int unsigned SHORT_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic long_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(LONG_LEN);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    last;

    always_comb begin
        st_d = st_q;
        last = en_i && (st_q.cnt >= (long_i ? LONG_LAST : SHORT_LAST));
        if (en_i) begin
            st_d.cnt = last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_o = last;
endmodule

// File: rtl/aux_toggle_lane.sv
`timescale 1ns/1ps
module aux_toggle_lane #(
    parameter int unsigned BUDGET = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic active_i,
    input  logic din_i,
    input  logic last_i,
    output logic over_o
);
    localparam int unsigned CNT_W = $clog2(BUDGET + 2);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(BUDGET + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BUDGET);

    typedef struct packed {
        logic             prev;
        logic             have_prev;
        logic             merge;
        logic [CNT_W-1:0] cnt;
        logic             over;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    logic             seen;
    logic             counted;
    logic [CNT_W-1:0] total;

    always_comb begin
        st_d      = st_q;
        st_d.over = 1'b0;
        seen      = 1'b0;
        counted   = 1'b0;
        total     = st_q.cnt;
        if (!active_i) begin
            st_d.have_prev = 1'b0;
            st_d.merge     = 1'b0;
            st_d.cnt       = '0;
        end else if (en_i) begin
            seen    = st_q.have_prev && (din_i != st_q.prev);
            counted = seen && !st_q.merge;
            if (counted && (st_q.cnt != SAT)) begin
                total = st_q.cnt + 1'b1;
            end
            st_d.prev      = din_i;
            st_d.have_prev = 1'b1;
            st_d.merge     = counted;
            if (last_i) begin
                st_d.over = (total > LIMIT);
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = total;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign over_o = st_q.over;
endmodule

// File: rtl/aux_toggle_budget.sv
`timescale 1ns/1ps
module aux_toggle_budget
    import aux_toggle_pkg::*;
#(
    parameter int unsigned NCH       = 2,
    parameter int unsigned LONG_LEN  = LONG_WIN_DEF,
    parameter int unsigned SHORT_LEN = SHORT_WIN_DEF,
    parameter int unsigned BUDGET    = BUDGET_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [1:0]     mode_i,
    input  logic [NCH-1:0] din_i,
    output logic [NCH-1:0] viol_o,
    output logic           err_o
);
    typedef struct packed {
        logic err;
    } top_st_t;

    aux_mode_e      mode;
    logic           long_win;
    logic           dual;
    logic           win_last;
    logic [NCH-1:0] lane_over;
    top_st_t        st_d, st_q;

    assign mode     = aux_mode_e'(mode_i);
    assign long_win = (mode == MODE_SINGLE) || (mode == MODE_RSVD);
    assign dual     = (mode == MODE_DUAL);

    aux_toggle_window #(
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .long_i (long_win),
        .last_o (win_last)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic act;
        if (i == 0) begin : g_main
            assign act = 1'b1;
        end else begin : g_side
            assign act = dual;
        end
        aux_toggle_lane #(
            .BUDGET (BUDGET)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_i),
            .active_i (act),
            .din_i    (din_i[i]),
            .last_i   (win_last),
            .over_o   (lane_over[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = st_q.err | (|lane_over);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_o = lane_over;
    assign err_o  = st_q.err;
endmodule

// File: rtl/aux_toggle_budget_chk.sv
`timescale 1ns/1ps
module aux_toggle_budget_chk #(
    parameter int unsigned NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_i,
    input logic [1:0]     mode_i,
    input logic [NCH-1:0] din_i,
    input logic [NCH-1:0] viol_o,
    input logic           err_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_pulse
        assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            viol_o[i] |=> !viol_o[i]);
    end

    assert_enabled_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o != '0) |-> $past(en_i));

    if (NCH > 1) begin : g_side
        assert_side_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (viol_o[NCH-1:1] != '0) |-> ($past(mode_i) == 2'b01));
    end

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_err_after_viol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o != '0) |=> err_o);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(viol_o) != '0));

    logic unused_din;
    assign unused_din = ^din_i;
endmodule

bind aux_toggle_budget aux_toggle_budget_chk #(.NCH(NCH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .mode_i (mode_i),
    .din_i  (din_i),
    .viol_o (viol_o),
    .err_o  (err_o)
);

// File: tb/aux_toggle_budget_tb.sv
`timescale 1ns/1ps
module aux_toggle_budget_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [1:0] din_i = 2'b00;
    logic [1:0] viol_o;
    logic       err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    aux_toggle_budget u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .mode_i (mode_i),
        .din_i  (din_i),
        .viol_o (viol_o),
        .err_o  (err_o)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [9:0] k0;
        logic [9:0] g0;
        logic [9:0] k1;
        logic [9:0] g1;
        logic [1:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 10'd2, 10'd5,   10'd0, 10'd0, 2'b00},
        '{2'b00, 10'd3, 10'd5,   10'd0, 10'd0, 2'b01},
        '{2'b00, 10'd4, 10'd1,   10'd0, 10'd0, 2'b00},
        '{2'b00, 10'd5, 10'd1,   10'd0, 10'd0, 2'b01},
        '{2'b00, 10'd0, 10'd0,   10'd5, 10'd5, 2'b00},
        '{2'b01, 10'd0, 10'd0,   10'd3, 10'd3, 2'b10},
        '{2'b01, 10'd2, 10'd4,   10'd2, 10'd4, 2'b00},
        '{2'b01, 10'd3, 10'd2,   10'd0, 10'd0, 2'b01},
        '{2'b10, 10'd3, 10'd7,   10'd3, 10'd7, 2'b01},
        '{2'b10, 10'd2, 10'd20,  10'd0, 10'd0, 2'b00},
        '{2'b11, 10'd3, 10'd100, 10'd0, 10'd0, 2'b01},
        '{2'b01, 10'd3, 10'd50,  10'd4, 10'd1, 2'b01}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge: drive inputs, take one posedge, return at the next negedge.
    task automatic cyc(input logic en, input logic [1:0] d);
        en_i  = en;
        din_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n  = 1'b0;
        en_i   = 1'b0;
        din_i  = 2'b00;
        mode_i = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic lvl(input int c, input int k, input int g);
        int n = 0;
        for (int j = 0; j < k; j++) if (10 + j * g <= c) n++;
        return n[0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic d0;
        logic d1;
        // R1: reset state
        do_reset(2'b00);
        check("R1 viol after reset", viol_o, 0);
        check("R1 err after reset", err_o, 0);
        for (int c = 0; c < 50; c++) cyc(1'b1, 2'b00);
        check("R1 viol mid-window", viol_o, 0);

        // Table walk: R2 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            int win;
            win = (VECS[v].mode == 2'b01 || VECS[v].mode == 2'b10) ? 128 : 512;
            do_reset(VECS[v].mode);
            for (int c = 0; c < win; c++) begin
                cyc(1'b1, {lvl(c, int'(VECS[v].k1), int'(VECS[v].g1)),
                           lvl(c, int'(VECS[v].k0), int'(VECS[v].g0))});
                if (c == win - 2) check($sformatf("R2 vec%0d no early close", v), viol_o, 0);
                if (c == win - 1) check($sformatf("R5/R6/R7 vec%0d window verdict", v), viol_o, VECS[v].exp);
            end
            cyc(1'b1, din_i);
            check($sformatf("R5 vec%0d pulse ends", v), viol_o, 0);
            check($sformatf("R8 vec%0d err", v), err_o, {31'd0, |VECS[v].exp});
        end

        // R3: glitches during disabled cycles are invisible; windows count enabled cycles
        do_reset(2'b01);
        d0 = 1'b0;
        for (int c = 0; c < 128; c++) begin
            cyc(1'b0, {~1'b0, ~d0});
            if (c == 10 || c == 30 || c == 50) d0 = ~d0;
            cyc(1'b1, {1'b0, d0});
            if (c == 126) check("R3 no close before 128 enabled", viol_o, 0);
        end
        check("R3 enabled-only sampling", viol_o, 2'b01);

        // R4: merge across a window boundary, short windows
        do_reset(2'b10);
        d0 = 1'b0;
        for (int c = 0; c < 256; c++) begin
            if (c == 127 || c == 128 || c == 140 || c == 150) d0 = ~d0;
            cyc(1'b1, {1'b0, d0});
            if (c == 127) check("R4 first window", viol_o, 0);
            if (c == 255) check("R4 merged pair across boundary", viol_o, 0);
        end

        // R8: sticky error across a later clean window
        for (int c = 256; c < 512; c++) begin
            if (c == 260 || c == 270 || c == 280) d0 = ~d0;
            cyc(1'b1, {1'b0, d0});
            if (c == 383) check("R5 third window violates", viol_o, 2'b01);
            if (c == 384) check("R8 err set", err_o, 1);
            if (c == 511) begin
                check("R8 clean window", viol_o, 0);
                check("R8 err held", err_o, 1);
            end
        end

        // R9 + R7: shorten window mid-way, lane 1 history cleared
        do_reset(2'b00);
        d0 = 1'b0;
        d1 = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (c == 10 || c == 20 || c == 30) d0 = ~d0;
            if (c % 5 == 0) d1 = ~d1;
            cyc(1'b1, {d1, d0});
        end
        check("R9 no close at 300 in long mode", viol_o, 0);
        mode_i = 2'b01;
        cyc(1'b1, {~d1, d0});
        check("R9 early close after mode change", viol_o, 2'b01);
        cyc(1'b1, {~d1, d0});
        check("R9 R7 next window open", viol_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule